// File: doc/BRIEF.md
# Dual-Mode Character Memory Write Port

This block takes character codes from a host processor bus and keeps them in a small character memory, eight entries of six bits by default. The host writes with an active-low write strobe, qualified by an active-low chip select. Both pass through synchronizers into the block clock. Each write has two phases. When the combined strobe becomes active, the block captures the mode bit and, depending on that mode, either a target address or a serial-enable flag. When the strobe is released, the block captures the data word and stores it.

In random mode the host names the target entry on the three shared select lines. Because the address is held from the strobe's start, the same six wires can carry the address first and the data afterwards. In sequential mode an internal slot counter chooses the entry and advances after each accepted write. After the last slot is filled the block raises a full flag. That flag can feed the serial-enable line of a following display, so several displays can be chained. In sequential mode the second select line acts as an active-low clear. Clear blanks every entry and rewinds the counter without waiting for a strobe.

A read port indexed by character number returns the stored codes to the display scan logic.

Top module: `chrmem_write_if`

## Requirements
- R1: A write phase occurs only while wr_n_i and cs_n_i are both low. The strobe starts on the later of their falling edges and ends on the earlier of their rising edges. If either input stays high, the memory does not change.
- R2: mode_i is captured only when the strobe starts: 0 selects random mode and 1 selects sequential mode. Changing mode_i between strobes has no effect.
- R3: In random mode the entry address is sel_i[2:0], captured when the strobe starts. Changes on sel_i later in the same strobe do not affect which entry is written.
- R4: data_i is captured when the strobe ends and written to the selected entry. Outside strobe release and clear, no entry changes.
- R5: In sequential mode, holding sel_i[1] low clears the memory without any strobe. Every entry is set to the blank code, which has only bit 5 set (0x20). The slot counter returns to 0 and the full flag drops.
- R6: In random mode, sel_i[1] is only an address bit. Holding it low clears nothing.
- R7: In sequential mode, sel_i[0] is a write enable captured when the strobe starts. When the enable is 1, the write goes to the slot counter's entry and the counter advances by one when the strobe ends. When the enable is 0, neither the memory nor the counter changes.
- R8: After the write that fills slot 7, the counter wraps to 0 and full_o goes high. full_o stays high until a clear.
- R9: While full, sequential writes change neither the memory nor the counter.
- R10: full_oe_o rises when the first sequential-mode strobe ends. It falls when a random-mode strobe starts. full_o is high only while full_oe_o is high.
- R11: After reset, every entry holds 0x20, the counter is 0, the mode is random, and full_o and full_oe_o are low.
- R12: rd_code_o returns, combinationally, the entry selected by rd_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n_i | input | 1 | Active-low write strobe from the host |
| cs_n_i | input | 1 | Active-low chip select that qualifies the strobe |
| mode_i | input | 1 | Mode select captured at strobe start: 0 random, 1 sequential |
| sel_i | input | 3 | Random mode: entry address. Sequential mode: bit 0 is write enable, bit 1 is active-low clear |
| data_i | input | 6 | Character code captured at strobe end |
| rd_idx_i | input | 3 | Character index for the scan read port |
| rd_code_o | output | 6 | Stored code at rd_idx_i |
| full_o | output | 1 | Sequential slot counter has wrapped |
| full_oe_o | output | 1 | Drive enable for the shared full/address pin |

## Verification
A wrong slot counter shows up at the next accepted sequential write. That code lands in the wrong entry, and the read port reveals it within a few cycles of the strobe release. A wrong full flag either lets a ninth write overwrite slot 0 or blocks the eighth. A mode latch updated at the wrong moment shows up in two ways. A held-low second select line blanks the memory in random mode, or the drive enable changes at the wrong strobe phase. The bench checks the read port and full outputs within six cycles of every strobe edge and every clear.

// File: rtl/chrmem_pkg.sv
package chrmem_pkg;

   typedef enum logic {
      MODE_RANDOM     = 1'b0,
      MODE_SEQUENTIAL = 1'b1
   } wr_mode_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/chrmem_sync.sv
module chrmem_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] stage_q;

   if (STAGES < chrmem_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("chrmem_sync: STAGES below minimum");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RESET_VAL;
            else        stage_q[s] <= d_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RESET_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/chrmem_strobe.sv
module chrmem_strobe #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_n_i,
   input  logic cs_n_i,
   output logic fall_o,
   output logic rise_o
);

   logic strobe_n_raw;
   logic strobe_n_s;
   logic strobe_n_prev_q;

   // Strobe is active only while both enables are low.
   assign strobe_n_raw = wr_n_i | cs_n_i;

   chrmem_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (strobe_n_raw),
      .q_o   (strobe_n_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_n_prev_q <= 1'b1;
      else        strobe_n_prev_q <= strobe_n_s;
   end

   assign fall_o =  strobe_n_prev_q & ~strobe_n_s;
   assign rise_o = ~strobe_n_prev_q &  strobe_n_s;

endmodule

// File: rtl/chrmem_seq_ctr.sv
module chrmem_seq_ctr #(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] slot_o,
   output logic              full_o
);

   localparam logic [ADDR_W-1:0] LAST_SLOT = '1;

   logic [ADDR_W-1:0] slot_q;
   logic              full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         full_q <= 1'b0;
      end else if (clr_i) begin
         slot_q <= '0;
         full_q <= 1'b0;
      end else if (adv_i && !full_q) begin
         slot_q <= slot_q + 1'b1;
         if (slot_q == LAST_SLOT) full_q <= 1'b1;
      end
   end

   assign slot_o = slot_q;
   assign full_o = full_q;

endmodule

// File: rtl/chrmem_store.sv
module chrmem_store #(
   parameter int unsigned              DATA_W     = 6,
   parameter int unsigned              ADDR_W     = 3,
   parameter logic [DATA_W-1:0]        BLANK_CODE = {1'b1, {(DATA_W-1){1'b0}}},
   localparam int unsigned             DEPTH      = 1 << ADDR_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      we_i,
   input  logic [ADDR_W-1:0]         waddr_i,
   input  logic [DATA_W-1:0]         wdata_i,
   input  logic [ADDR_W-1:0]         raddr_i,
   output logic [DATA_W-1:0]         rdata_o,
   output logic [DEPTH*DATA_W-1:0]   image_o
);

   logic [DATA_W-1:0] cell_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      localparam logic [ADDR_W-1:0] IDX = ADDR_W'(e);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cell_q[e] <= BLANK_CODE;
         else if (clr_i)                      cell_q[e] <= BLANK_CODE;
         else if (we_i && (waddr_i == IDX))   cell_q[e] <= wdata_i;
      end
      assign image_o[e*DATA_W +: DATA_W] = cell_q[e];
   end

   assign rdata_o = cell_q[raddr_i];

endmodule

// File: rtl/chrmem_write_if.sv
module chrmem_write_if #(
   parameter int unsigned       DATA_W      = 6,
   parameter int unsigned       ADDR_W      = 3,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] BLANK_CODE  = {1'b1, {(DATA_W-1){1'b0}}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n_i,
   input  logic              cs_n_i,
   input  logic              mode_i,
   input  logic [ADDR_W-1:0] sel_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0] rd_idx_i,
   output logic [DATA_W-1:0] rd_code_o,
   output logic              full_o,
   output logic              full_oe_o
);

   import chrmem_pkg::*;

   localparam int unsigned DEPTH   = 1 << ADDR_W;
   localparam int unsigned SEN_BIT = 0;
   localparam int unsigned CLR_BIT = 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("chrmem_write_if: ADDR_W must hold enable and clear bits");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("chrmem_write_if: DATA_W must be positive");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("chrmem_write_if: SYNC_STAGES too small");
   end

   logic                    fall_p;
   logic                    rise_p;
   logic                    clr_pin_s;
   logic                    clr_act;
   wr_mode_e                mode_q;
   logic [ADDR_W-1:0]       addr_q;
   logic                    sen_q;
   logic                    oe_q;
   logic [ADDR_W-1:0]       slot_q;
   logic                    full_q;
   logic                    seq_adv;
   logic                    we;
   logic [ADDR_W-1:0]       waddr;
   logic [DEPTH*DATA_W-1:0] mem_image;

   chrmem_strobe #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_n_i (wr_n_i),
      .cs_n_i (cs_n_i),
      .fall_o (fall_p),
      .rise_o (rise_p)
   );

   chrmem_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_clr_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sel_i[CLR_BIT]),
      .q_o   (clr_pin_s)
   );

   // The clear role of the shared line exists only in sequential mode.
   assign clr_act = (mode_q == MODE_SEQUENTIAL) && !clr_pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RANDOM;
         addr_q <= '0;
         sen_q  <= 1'b0;
         oe_q   <= 1'b0;
      end else if (fall_p) begin
         mode_q <= wr_mode_e'(mode_i);
         if (wr_mode_e'(mode_i) == MODE_RANDOM) begin
            addr_q <= sel_i;
            oe_q   <= 1'b0;
         end else begin
            sen_q  <= sel_i[SEN_BIT];
         end
      end else if (rise_p) begin
         oe_q <= (mode_q == MODE_SEQUENTIAL);
      end
   end

   assign seq_adv = rise_p && (mode_q == MODE_SEQUENTIAL) && sen_q;

   chrmem_seq_ctr #(
      .ADDR_W (ADDR_W)
   ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_act),
      .adv_i  (seq_adv),
      .slot_o (slot_q),
      .full_o (full_q)
   );

   always_comb begin
      if (mode_q == MODE_SEQUENTIAL) begin
         waddr = slot_q;
         we    = seq_adv && !full_q;
      end else begin
         waddr = addr_q;
         we    = rise_p;
      end
   end

   chrmem_store #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .BLANK_CODE (BLANK_CODE)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_act),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (data_i),
      .raddr_i (rd_idx_i),
      .rdata_o (rd_code_o),
      .image_o (mem_image)
   );

   assign full_oe_o = oe_q;
   assign full_o    = oe_q & full_q;

endmodule

// File: rtl/chrmem_write_if_chk.sv
module chrmem_write_if_chk #(
   parameter int unsigned       DATA_W     = 6,
   parameter int unsigned       ADDR_W     = 3,
   parameter logic [DATA_W-1:0] BLANK_CODE = {1'b1, {(DATA_W-1){1'b0}}},
   localparam int unsigned      DEPTH      = 1 << ADDR_W
) (
   input logic                    clk,
   input logic                    rst_n,
   input chrmem_pkg::wr_mode_e    mode_q,
   input logic                    clr_act,
   input logic                    full_q,
   input logic [ADDR_W-1:0]       slot_q,
   input logic                    full_oe_o,
   input logic                    fall_p,
   input logic                    rise_p,
   input logic [DEPTH*DATA_W-1:0] image
);

   import chrmem_pkg::*;

   assert_mode_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_p |=> $stable(mode_q));

   assert_mem_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_p && !clr_act) |=> $stable(image));

   assert_clear_blanks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_act |=> (image == {DEPTH{BLANK_CODE}}) && (slot_q == '0) && !full_q);

   assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !clr_act) |=> full_q);

   assert_full_slot_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> (slot_q == '0));

   assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && mode_q == MODE_SEQUENTIAL && !clr_act) |=> $stable(image));

   assert_oe_seq_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      full_oe_o |-> (mode_q == MODE_SEQUENTIAL));

endmodule

bind chrmem_write_if chrmem_write_if_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .BLANK_CODE (BLANK_CODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_q    (mode_q),
   .clr_act   (clr_act),
   .full_q    (full_q),
   .slot_q    (slot_q),
   .full_oe_o (full_oe_o),
   .fall_p    (fall_p),
   .rise_p    (rise_p),
   .image     (mem_image)
);

// File: tb/chrmem_write_if_tb.sv
`timescale 1ns/1ps
module chrmem_write_if_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_n = 1'b1;
   logic       cs_n = 1'b1;
   logic       mode = 1'b0;
   logic [2:0] sel = 3'b011;
   logic [5:0] data = '0;
   logic [2:0] rd_idx = '0;
   logic [5:0] rd_code;
   logic       full;
   logic       full_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   localparam logic [5:0] BLANK = 6'h20;

   always #2 clk = ~clk;

   chrmem_write_if u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_n_i    (wr_n),
      .cs_n_i    (cs_n),
      .mode_i    (mode),
      .sel_i     (sel),
      .data_i    (data),
      .rd_idx_i  (rd_idx),
      .rd_code_o (rd_code),
      .full_o    (full),
      .full_oe_o (full_oe)
   );

   typedef struct packed {
      logic [2:0] sel_fall;
      logic [2:0] sel_rise;
      logic [5:0] wdata;
      logic [2:0] ridx;
      logic [5:0] exp;
   } vec_t;

   // Random-mode writes; the select lines change before release (R3).
   localparam vec_t VEC [6] = '{
      '{3'd5, 3'd2, 6'h15, 3'd5, 6'h15},
      '{3'd0, 3'd7, 6'h3F, 3'd0, 6'h3F},
      '{3'd7, 3'd0, 6'h01, 3'd7, 6'h01},
      '{3'd2, 3'd5, 6'h2A, 3'd2, 6'h2A},
      '{3'd2, 3'd3, 6'h11, 3'd2, 6'h11},
      '{3'd3, 3'd5, 6'h00, 3'd5, 6'h15}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_rd(input string tag, input logic [2:0] idx, input logic [5:0] exp);
      rd_idx = idx;
      #1;
      check(tag, {2'b00, rd_code}, {2'b00, exp});
   endtask

   task automatic press(input logic m, input logic [2:0] s, input logic [5:0] d);
      @(negedge clk);
      mode = m; sel = s; data = d;
      wr_n = 1'b0; cs_n = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic unpress(input logic [2:0] s);
      sel = s; wr_n = 1'b1; cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic wr(input logic m, input logic [2:0] sf, input logic [2:0] sr, input logic [5:0] d);
      press(m, sf, d);
      unpress(sr);
   endtask

   task automatic do_clear;
      @(negedge clk);
      sel = 3'b001;
      repeat (6) @(negedge clk);
      sel = 3'b011;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R11: reset state
      for (int i = 0; i < 8; i++) chk_rd("R11 reset blank", 3'(i), BLANK);
      check("R11 full low", {7'b0, full}, 8'h0);
      check("R11 oe low", {7'b0, full_oe}, 8'h0);

      // Table walk: R3 address latched at strobe start, R4 data at release, R12 read
      foreach (VEC[k]) begin
         wr(1'b0, VEC[k].sel_fall, VEC[k].sel_rise, VEC[k].wdata);
         chk_rd("R3 R4 R12 random write", VEC[k].ridx, VEC[k].exp);
      end
      chk_rd("R4 overwrite entry 3", 3'd3, 6'h00);

      // R1: chip select high blocks the write strobe
      @(negedge clk);
      mode = 1'b0; sel = 3'd4; data = 6'h2B; wr_n = 1'b0; cs_n = 1'b1;
      repeat (8) @(negedge clk);
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
      chk_rd("R1 cs high no write", 3'd4, BLANK);
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      chk_rd("R1 wr high no write", 3'd4, BLANK);
      sel = 3'b011;
      repeat (4) @(negedge clk);

      // R10: drive enable rises only at release of first sequential strobe
      press(1'b1, 3'b011, 6'h07);
      check("R10 oe low during seq strobe", {7'b0, full_oe}, 8'h0);
      unpress(3'b011);
      check("R10 oe high after seq release", {7'b0, full_oe}, 8'h1);
      chk_rd("R7 seq write slot0", 3'd0, 6'h07);

      // R5: clear in sequential mode
      do_clear();
      chk_rd("R5 clear slot0", 3'd0, BLANK);
      chk_rd("R5 clear slot5", 3'd5, BLANK);

      // R7/R8: fill all eight slots
      for (int i = 0; i < 8; i++) begin
         wr(1'b1, 3'b011, 3'b011, 6'(8'h10 + i));
         if (i == 6) check("R8 full low after seven", {7'b0, full}, 8'h0);
      end
      check("R8 full after eighth", {7'b0, full}, 8'h1);
      for (int i = 0; i < 8; i++) chk_rd("R7 seq slot content", 3'(i), 6'(8'h10 + i));

      // R9: write while full is ignored
      wr(1'b1, 3'b011, 3'b011, 6'h3E);
      chk_rd("R9 full blocks slot0", 3'd0, 6'h10);
      check("R8 full sticky", {7'b0, full}, 8'h1);

      // R5: clear drops full and rewinds
      do_clear();
      check("R5 full cleared", {7'b0, full}, 8'h0);
      wr(1'b1, 3'b011, 3'b011, 6'h21);
      chk_rd("R5 rewound to slot0", 3'd0, 6'h21);

      // R7: enable low writes nothing and holds counter
      wr(1'b1, 3'b010, 3'b011, 6'h22);
      wr(1'b1, 3'b011, 3'b011, 6'h23);
      chk_rd("R7 enable low skipped", 3'd1, 6'h23);
      chk_rd("R7 slot2 untouched", 3'd2, BLANK);

      // R10/R2: back to random mode
      press(1'b0, 3'b110, 6'h0C);
      check("R10 oe low at random strobe start", {7'b0, full_oe}, 8'h0);
      unpress(3'b110);
      chk_rd("R2 random write after switch", 3'd6, 6'h0C);

      // R6: second select line low in random mode does not clear
      @(negedge clk);
      sel = 3'b000;
      repeat (8) @(negedge clk);
      chk_rd("R6 no clear in random", 3'd6, 6'h0C);
      chk_rd("R6 slot0 kept", 3'd0, 6'h21);

      // R2: mode input alone does not change the mode
      mode = 1'b1;
      repeat (8) @(negedge clk);
      chk_rd("R2 mode held without strobe", 3'd0, 6'h21);
      check("R2 oe stays low", {7'b0, full_oe}, 8'h0);

      // R11: reset mid-run restores blank state
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      sel = 3'b011; mode = 1'b0;
      repeat (2) @(negedge clk);
      chk_rd("R11 reset again", 3'd6, BLANK);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule